// File: doc/BRIEF.md
# Predicated Vector Minimum Reduction

This block takes one wide vector, a per-byte predicate and a two-bit lane size code, and returns the smallest lane value as a single scalar. The lane width is chosen per operation at run time, so the same hardware reduces a vector as bytes, half-words, words or double-words. Lanes whose predicate is clear take no part. They are replaced by the largest value the lane width can hold, which is the identity of a minimum. When no lane is active, that identity is the result.

Internally every byte position of the vector becomes one leaf of a balanced comparison tree. Each leaf holds a 64-bit normalised copy of the lane that starts there, or the identity. A pipeline register can be placed after any tree level through a bit mask, so one operation can be accepted on every clock. The result leaves through a registered output, cut to the lane width and zero-extended to 64 bits. A parameter switches the whole block to an unsigned comparison.

Top module: `vec_min_reduce`

## Requirements
- R1: The size code sets the lane width to 8 << code bits: 0 is 8, 1 is 16, 2 is 32 and 3 is 64. The vector holds VLEN / width lanes, and lane e occupies bits e*width up to e*width+width-1.
- R2: Lane e is active exactly when predicate bit e*(width/8) is set, which is the bit of the lane's lowest byte. The other predicate bits inside the lane have no effect on the result.
- R3: An inactive lane never changes the result. For any predicate, the output equals the minimum over the active lanes only.
- R4: With the signed comparison, when no lane is active the output is 2^(width-1)-1 at the current lane width.
- R5: With UNS=0, lanes are compared as two's-complement integers, so a lane holding the most negative value (only its top bit set) is the minimum whenever it is active.
- R6: Only the low width bits of the minimum are driven on out_min. Bits width to 63 are zero.
- R7: out_valid repeats in_valid delayed by LATENCY = 2 + (the number of set bits of PIPE_MASK among its low clog2(VLEN/8) bits). A new operation is accepted on every cycle, and each result belongs to the operation presented LATENCY cycles earlier.
- R8: With UNS=1, lanes are compared as unsigned integers and the identity, which is also the output when no lane is active, is 2^width-1.
- R9: A synchronous active-high reset clears out_valid, and in_valid is ignored while reset is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_vec | input | VLEN | Source vector; lane e at bits e*width upward |
| in_pred | input | VLEN/8 | One predicate bit per byte of the vector |
| in_size | input | 2 | Lane size code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| out_valid | output | 1 | Result present on out_min |
| out_min | output | 64 | Minimum active lane, zero-extended above the lane width |

## Verification
The bench builds two instances and checks both against a behavioural reference loop. The first is signed, with VLEN=256 and a register after every tree level, which gives 32 byte leaves and a latency of 7. The second is unsigned, with VLEN=192 and PIPE_MASK=5. Its 24 leaves are not a power of two, so the identity padding of the tree is exercised, and its mix of registered and combinational levels gives a latency of 4. Each instance is driven with all four size codes, all-clear predicates, predicates that set only the non-leading bytes of each lane, single active lanes, most-negative lanes, and random traffic with idle gaps.

// File: rtl/vmin_pkg.sv
package vmin_pkg;

  localparam int WMAX = 64;

  typedef enum logic [1:0] {
    SZ_B8  = 2'b00,
    SZ_B16 = 2'b01,
    SZ_B32 = 2'b10,
    SZ_B64 = 2'b11
  } lane_size_e;

  // low-order mask covering one lane of the given size
  function automatic logic [WMAX-1:0] width_mask(lane_size_e sz);
    logic [WMAX-1:0] m;
    case (sz)
      SZ_B8:   m = 64'h0000_0000_0000_00FF;
      SZ_B16:  m = 64'h0000_0000_0000_FFFF;
      SZ_B32:  m = 64'h0000_0000_FFFF_FFFF;
      default: m = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    return m;
  endfunction

  function automatic int lane_bytes(lane_size_e sz);
    return 1 << int'(sz);
  endfunction

  // reduction identity at the lane width, in its 64-bit normalised form
  function automatic logic [WMAX-1:0] lane_ident(lane_size_e sz, bit uns);
    logic [WMAX-1:0] m;
    m = width_mask(sz);
    return uns ? m : (m >> 1);
  endfunction

  // bring a lane to 64 bits: sign-extend (signed) or zero-extend (unsigned)
  function automatic logic [WMAX-1:0] widen(logic [WMAX-1:0] raw, lane_size_e sz, bit uns);
    logic [WMAX-1:0] m;
    logic [WMAX-1:0] t;
    m = width_mask(sz);
    t = raw & m;
    if (!uns && ((t & (m ^ (m >> 1))) != '0)) t = t | ~m;
    return t;
  endfunction

  function automatic bit is_less(logic [WMAX-1:0] a, logic [WMAX-1:0] b, bit uns);
    return uns ? (a < b) : ($signed(a) < $signed(b));
  endfunction

  // true when x is a legal normalised leaf for the lane size
  function automatic bit leaf_fits(logic [WMAX-1:0] x, lane_size_e sz, bit uns);
    logic [WMAX-1:0] m;
    logic [WMAX-1:0] hi;
    bit neg;
    m   = width_mask(sz);
    hi  = x & ~m;
    neg = (x & (m ^ (m >> 1))) != '0;
    if (uns || !neg) return hi == '0;
    return hi == ~m;
  endfunction

  function automatic int count_set(logic [31:0] mask, int n);
    int c;
    c = 0;
    for (int i = 0; i < n && i < 32; i++) if (mask[i]) c++;
    return c;
  endfunction

endpackage

// File: rtl/vmin_leaf_map.sv
module vmin_leaf_map
  import vmin_pkg::*;
#(
  parameter int VLEN = 256,
  parameter bit UNS  = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [VLEN-1:0]                   in_vec,
  input  logic [VLEN/8-1:0]                 in_pred,
  input  logic [1:0]                        in_size,
  output logic                              v_q,
  output lane_size_e                        size_q,
  output logic [VLEN/8-1:0][WMAX-1:0]       leaf_q
);

  localparam int NSLOT = VLEN / 8;

  // zero tail so every slot can take a full 64-bit window
  logic [VLEN+WMAX-1:0]          vext;
  lane_size_e                    sz;
  logic [NSLOT-1:0][WMAX-1:0]    leaf_d;

  assign vext = {{WMAX{1'b0}}, in_vec};
  assign sz   = lane_size_e'(in_size);

  // slot s holds the lane starting at byte s, or the identity
  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      logic lead;
      lead = ((s & (lane_bytes(sz) - 1)) == 0);
      if (lead && in_pred[s])
        leaf_d[s] = widen(vext[s*8 +: WMAX], sz, UNS);
      else
        leaf_d[s] = lane_ident(sz, UNS);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= in_valid;
    size_q <= sz;
    leaf_q <= leaf_d;
  end

  // R1: every captured leaf is a proper extension of a lane of the captured size
  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    a_r1_leaf_fits: assert property (@(posedge clk) disable iff (rst)
      v_q |-> leaf_fits(leaf_q[s], size_q, UNS));
  end

endmodule

// File: rtl/vmin_tree_level.sv
module vmin_tree_level
  import vmin_pkg::*;
#(
  parameter int N_IN = 2,
  parameter bit UNS  = 1'b0,
  parameter bit REG  = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          v_i,
  input  lane_size_e                    size_i,
  input  logic [N_IN-1:0][WMAX-1:0]     d_i,
  output logic                          v_o,
  output lane_size_e                    size_o,
  output logic [N_IN/2-1:0][WMAX-1:0]   d_o
);

  localparam int N_OUT = N_IN / 2;

  logic [N_OUT-1:0][WMAX-1:0] pick;

  always_comb begin
    for (int p = 0; p < N_OUT; p++)
      pick[p] = is_less(d_i[2*p+1], d_i[2*p], UNS) ? d_i[2*p+1] : d_i[2*p];
  end

  // R3: no pair result lies above either of its operands
  always_comb begin
    for (int p = 0; p < N_OUT; p++) begin
      a_r3_min_bound: assert (!is_less(d_i[2*p], pick[p], UNS) &&
                              !is_less(d_i[2*p+1], pick[p], UNS));
    end
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) v_o <= 1'b0;
      else     v_o <= v_i;
      size_o <= size_i;
      d_o    <= pick;
    end
  end else begin : g_comb
    assign v_o    = v_i;
    assign size_o = size_i;
    assign d_o    = pick;
  end

endmodule

// File: rtl/vmin_out_fmt.sv
module vmin_out_fmt
  import vmin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              v_i,
  input  lane_size_e        size_i,
  input  logic [WMAX-1:0]   d_i,
  output logic              out_valid,
  output logic [WMAX-1:0]   out_min
);

  lane_size_e size_q;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v_i;
    size_q  <= size_i;
    out_min <= d_i & width_mask(size_i);
  end

  // R6: nothing above the lane width reaches the port
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_min & ~width_mask(size_q)) == '0));

endmodule

// File: rtl/vec_min_reduce.sv
module vec_min_reduce
  import vmin_pkg::*;
#(
  parameter int          VLEN      = 256,
  parameter bit          UNS       = 1'b0,
  parameter logic [31:0] PIPE_MASK = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VLEN-1:0]   in_vec,
  input  logic [VLEN/8-1:0] in_pred,
  input  logic [1:0]        in_size,
  output logic              out_valid,
  output logic [63:0]       out_min
);

  localparam int NSLOT   = VLEN / 8;
  localparam int LEVELS  = $clog2(NSLOT);
  localparam int NPAD    = 1 << LEVELS;
  localparam int LATENCY = 2 + count_set(PIPE_MASK, LEVELS);
  localparam logic [WMAX-1:0] PAD_VAL = UNS ? {WMAX{1'b1}} : {1'b0, {(WMAX-1){1'b1}}};

  logic                       lv;
  lane_size_e                 lsz;
  logic [NSLOT-1:0][WMAX-1:0] leaf;
  logic [NPAD-1:0][WMAX-1:0]  pad;

  vmin_leaf_map #(.VLEN(VLEN), .UNS(UNS)) u_map (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_vec   (in_vec),
    .in_pred  (in_pred),
    .in_size  (in_size),
    .v_q      (lv),
    .size_q   (lsz),
    .leaf_q   (leaf)
  );

  // fill the tree up to a power of two with the type's extreme value
  always_comb begin
    pad = {NPAD{PAD_VAL}};
    pad[NSLOT-1:0] = leaf;
  end

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int NI = NPAD >> k;
    logic                      vi;
    logic                      vo;
    lane_size_e                si;
    lane_size_e                so;
    logic [NI-1:0][WMAX-1:0]   di;
    logic [NI/2-1:0][WMAX-1:0] dout;

    if (k == 0) begin : g_first
      assign vi = lv;
      assign si = lsz;
      assign di = pad;
    end else begin : g_next
      assign vi = g_lvl[k-1].vo;
      assign si = g_lvl[k-1].so;
      assign di = g_lvl[k-1].dout;
    end

    vmin_tree_level #(.N_IN(NI), .UNS(UNS), .REG(PIPE_MASK[k])) u_lvl (
      .clk    (clk),
      .rst    (rst),
      .v_i    (vi),
      .size_i (si),
      .d_i    (di),
      .v_o    (vo),
      .size_o (so),
      .d_o    (dout)
    );
  end

  vmin_out_fmt u_fmt (
    .clk       (clk),
    .rst       (rst),
    .v_i       (g_lvl[LEVELS-1].vo),
    .size_i    (g_lvl[LEVELS-1].so),
    .d_i       (g_lvl[LEVELS-1].dout[0]),
    .out_valid (out_valid),
    .out_min   (out_min)
  );

  // R7 / R9: no result can appear before a full pipeline of cycles has passed since reset
  int unsigned warm;
  always_ff @(posedge clk) begin
    if (rst)                         warm <= 0;
    else if (warm < LATENCY)         warm <= warm + 1;
  end

  a_r7_valid_warm: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (warm == LATENCY));

endmodule

// File: tb/tb_vec_min_reduce.sv
module tb_min_lane_harness #(
  parameter int          VLEN      = 256,
  parameter bit          UNS       = 1'b0,
  parameter logic [31:0] PIPE_MASK = 32'hFFFF_FFFF,
  parameter int          LAT       = 7
) (
  input  logic clk,
  input  logic rst,
  output int   nchk,
  output int   nbad,
  output logic done
);

  typedef struct {
    bit          v;
    logic [63:0] val;
    int          w;
    string       tag;
  } exp_t;

  logic              in_valid;
  logic [VLEN-1:0]   in_vec;
  logic [VLEN/8-1:0] in_pred;
  logic [1:0]        in_size;
  logic              out_valid;
  logic [63:0]       out_min;

  exp_t q[$];

  vec_min_reduce #(.VLEN(VLEN), .UNS(UNS), .PIPE_MASK(PIPE_MASK)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .in_pred(in_pred), .in_size(in_size), .out_valid(out_valid), .out_min(out_min)
  );

  function automatic logic [63:0] lmask(int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  // sequential reference: walk the lanes one at a time
  function automatic logic [63:0] ref_min(logic [VLEN-1:0] vec, logic [VLEN/8-1:0] pred, int code);
    int w;
    logic [63:0] m;
    logic [63:0] ubest;
    longint sbest;
    w = 8 << code;
    m = lmask(w);
    ubest = m;
    sbest = longint'(m >> 1);
    for (int e = 0; e < VLEN / w; e++) begin
      if (pred[e*(w/8)]) begin
        logic [63:0] x;
        longint xs;
        x = 64'(vec >> (e*w)) & m;
        xs = longint'(x[w-1] ? (x | ~m) : x);
        if (UNS) begin
          if (x < ubest) ubest = x;
        end else begin
          if (xs < sbest) sbest = xs;
        end
      end
    end
    return UNS ? ubest : (64'(sbest) & m);
  endfunction

  function automatic logic [VLEN-1:0] rand_vec();
    logic [VLEN-1:0] v;
    for (int c = 0; c < VLEN / 32; c++) v[c*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VLEN-1:0] put_lane(logic [VLEN-1:0] v, int e, int w, logic [63:0] x);
    logic [VLEN-1:0] mm;
    mm = VLEN'(lmask(w)) << (e*w);
    return (v & ~mm) | ((VLEN'(x & lmask(w))) << (e*w));
  endfunction

  task automatic check_out(exp_t it);
    nchk++;
    if (out_valid !== it.v) begin
      nbad++;
      $display("FAIL R7 out_valid actual=%0b expected=%0b", out_valid, it.v);
    end
    if (it.v) begin
      nchk++;
      if (out_min !== it.val) begin
        nbad++;
        $display("FAIL %s w=%0d out_min actual=%h expected=%h", it.tag, it.w, out_min, it.val);
      end
      nchk++;
      if ((out_min & ~lmask(it.w)) != 64'd0) begin
        nbad++;
        $display("FAIL R6 upper bits actual=%h expected=%h", out_min & ~lmask(it.w), 64'd0);
      end
    end
  endtask

  task automatic send(logic [VLEN-1:0] vec, logic [VLEN/8-1:0] pred, int code, bit v, string tag);
    exp_t it;
    @(negedge clk);
    if (q.size() == LAT) check_out(q.pop_front());
    in_valid = v;
    in_vec   = vec;
    in_pred  = pred;
    in_size  = 2'(code);
    it.v   = v;
    it.val = ref_min(vec, pred, code);
    it.w   = 8 << code;
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    nchk = 0;
    nbad = 0;
    done = 1'b0;
    in_valid = 1'b1;
    in_vec = '0;
    in_pred = '1;
    in_size = 2'd0;
    // R9: valid held high during reset must not reach the output
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      nchk++;
      if (out_valid !== 1'b0) begin
        nbad++;
        $display("FAIL R9 out_valid in reset actual=%0b expected=0", out_valid);
      end
    end
    in_valid = 1'b0;
    wait (rst == 1'b0);

    // R4 / R8: no active lane gives the identity
    for (int c = 0; c < 4; c++) send(rand_vec(), '0, c, 1'b1, UNS ? "R8" : "R4");

    // R2: only the lowest-byte predicate bit of each lane counts
    for (int c = 1; c < 4; c++) begin
      logic [VLEN/8-1:0] p;
      for (int b = 0; b < VLEN / 8; b++) p[b] = ((b % (1 << c)) != 0);
      send(rand_vec(), p, c, 1'b1, "R2");
    end

    // R2: a single active lane, other bits of that lane varied
    for (int c = 0; c < 4; c++) begin
      for (int t = 0; t < 4; t++) begin
        int w;
        int e;
        logic [VLEN/8-1:0] p;
        w = 8 << c;
        e = $urandom % (VLEN / w);
        p = '0;
        for (int b = 0; b < w / 8; b++) p[e*(w/8) + b] = (b == 0) ? 1'b1 : 1'($urandom);
        send(rand_vec(), p, c, 1'b1, "R2");
      end
    end

    // R5: the most negative pattern in one lane
    for (int c = 0; c < 4; c++) begin
      for (int t = 0; t < 3; t++) begin
        int w;
        int e;
        w = 8 << c;
        e = $urandom % (VLEN / w);
        send(put_lane(rand_vec(), e, w, 64'd1 << (w - 1)), '1, c, 1'b1, UNS ? "R8" : "R5");
      end
    end

    // R1: all lanes active, every size, including all-ones lanes
    for (int c = 0; c < 4; c++) begin
      send('1, '1, c, 1'b1, "R1");
      send(rand_vec(), '1, c, 1'b1, "R1");
    end

    // R3 / R7: random predicates, back-to-back with idle gaps
    for (int i = 0; i < 400; i++) begin
      logic [VLEN/8-1:0] p;
      for (int b = 0; b < VLEN / 8; b++) p[b] = ($urandom % 3) == 0;
      send(rand_vec(), p, $urandom % 4, ($urandom % 4) != 0, UNS ? "R8" : "R3");
    end

    for (int i = 0; i < LAT; i++) send('0, '0, 0, 1'b0, "R7");
    @(negedge clk);
    if (q.size() == LAT) check_out(q.pop_front());
    done = 1'b1;
  end

endmodule

module tb_vec_min_reduce;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int   c_s, b_s, c_u, b_u;
  logic d_s, d_u;
  int   total, bad;

  tb_min_lane_harness #(.VLEN(256), .UNS(1'b0), .PIPE_MASK(32'hFFFF_FFFF), .LAT(7)) h_signed (
    .clk(clk), .rst(rst), .nchk(c_s), .nbad(b_s), .done(d_s));

  tb_min_lane_harness #(.VLEN(192), .UNS(1'b1), .PIPE_MASK(32'h0000_0005), .LAT(4)) h_unsigned (
    .clk(clk), .rst(rst), .nchk(c_u), .nbad(b_u), .done(d_u));

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fork
      wait (d_s && d_u);
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    total = c_s + c_u;
    bad   = b_s + b_u;
    if (timed_out && !(d_s && d_u)) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule